// File: doc/BRIEF.md
# Transceiver Startup and Lock Sequencer

This controller runs on the reference clock of a serial transceiver. It takes the transceiver through a timed bring-up schedule and drives the digital controls that each stage needs. First the PLL is held at its lowest frequency while bias settles. Then the PLL locks and the receiver front end begins to lock. Then the receiver acquires incoming data. After a short settling gap, receive data is declared valid and comma alignment may be enabled. Every stage length is given in microseconds and is turned into a cycle count at elaboration from the reference clock frequency parameter `REF_MHZ`.

After bring-up, the block keeps watching a receiver tracking input. When that input goes low, the receiver goes idle. When it returns high, a short relock interval runs before data is valid again. A qualified reset forces the analog side into a safe condition: minimum PLL frequency, serial pair forced, RX word held, phase selector and DPLL filter cleared. A low-power request powers the PLL down, produces a slow refresh enable and restarts the whole schedule on exit. A PLL bypass request also halts the schedule.

The power-up reset asserts asynchronously and is released through two flops. Every other control input passes through a two-flop synchronizer before the block uses it.

Top module: `xcvr_lock_seq`

## Requirements
- R1: The phase code is 0 while the power-up reset is high and for the first two rising edges after it falls, and it is 1 after the third. From phase 0 the block enters phase 1 on the edge after the synchronized qualified reset, bypass and low-power inputs are all low. Phase code values: 0 halted, 1 bias hold, 2 PLL lock, 3 receiver lock, 4 settle, 5 data valid, 6 idle, 7 relock.
- R2: Phase 1 lasts exactly 32·REF_MHZ cycles. `pll_min_hold` is high in phase 1 and low in phases 2 to 7 when no reset is qualified.
- R3: Counting from the first phase-1 cycle as cycle 0, phase 2 begins at cycle 32·REF_MHZ, phase 3 at 262·REF_MHZ, phase 4 at 326·REF_MHZ and phase 5 at 358·REF_MHZ. `rx_lock_start` is high in phases 2 to 7.
- R4: `data_valid` is high only in phase 5. It rises only when leaving phase 4 or phase 7.
- R5: `comma_det_en` equals `data_valid` AND the comma request input, where the comma request has two cycles of synchronizer delay.
- R6: In phase 5, a low `ref_track_en` moves the block to phase 6 on the third rising edge after the change. A later high moves it to phase 7 on the third rising edge. Phase 7 lasts 2·REF_MHZ cycles and then returns to phase 5.
- R7: `ref_track_en` has no effect in phases 1 to 4. The schedule of R3 is unchanged when the input is low during those phases.
- R8: A reset request counts only after its synchronized level has been high for REF_MHZ consecutive cycles (1 µs). A shorter pulse changes no output.
- R9: While a reset is qualified, `ser_force`, `pll_min_hold`, `rx_word_hold`, `phase_sel_rst` and `dpll_filt_rst` are all 1. `ser_force` = 1 means the positive serial leg is driven to 0 and the negative leg to 1. The phase is 0 from the next edge, and the schedule restarts at phase 1 once the qualified reset ends.
- R10: While the synchronized low-power request is high, `pll_pwr_dn` is 1, the phase is 0 from the next edge, and `refresh_en` pulses for one cycle in every REFRESH_DIV cycles. Leaving low power restarts the schedule at phase 1. `refresh_en` is 0 outside low power.
- R11: A synchronized PLL bypass request forces phase 0 from the next edge. The schedule restarts at phase 1 when it falls.
- R12: Raising `pwr_up_rst` forces the phase code to 0 and clears `data_valid` without waiting for a clock edge.

Expressed in cycles at REF_MHZ = 2 (illustrative):

| Event | Cycles from first phase-1 cycle |
|---|---|
| Phase 2 starts | 64 |
| Phase 3 starts | 524 |
| Phase 4 starts | 652 |
| Phase 5 starts | 716 |
| Relock length (phase 7) | 4 |
| Minimum reset pulse | 2 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| pwr_up_rst | input | 1 | Power-up reset, active high, asynchronous assert |
| rst_req | input | 1 | Transceiver reset request, active high, asynchronous |
| pll_bypass | input | 1 | PLL bypass request, halts the schedule |
| sleep_req | input | 1 | Low-power request |
| ref_track_en | input | 1 | Receiver tracking enable; low idles the receiver after bring-up |
| comma_req | input | 1 | Comma alignment request |
| pll_min_hold | output | 1 | Hold PLL at minimum frequency |
| rx_lock_start | output | 1 | Receiver front-end lock in progress or done |
| data_valid | output | 1 | Receive data on the parallel port is valid |
| comma_det_en | output | 1 | Comma detection enable |
| ser_force | output | 1 | Force serial pair to positive 0, negative 1 |
| rx_word_hold | output | 1 | Hold RX word at its last value |
| phase_sel_rst | output | 1 | Reset phase selection |
| dpll_filt_rst | output | 1 | Reset DPLL low-pass filter |
| pll_pwr_dn | output | 1 | PLL power-down |
| refresh_en | output | 1 | Refresh clock enable pulse in low power |
| phase_code | output | 3 | Current phase code |

## Verification
The full bring-up schedule is stepped cycle by cycle from three different starting events. The first start is release of the power-up reset. The second is the end of a qualified reset. The third is leaving low power. Every output is compared at every cycle, so a wrong boundary in any one path shows up as an error.

The comma request is swept at both levels across the data-valid boundary, which separates the gating from plain data-valid. Tracking is held low through the early phases to show that it is ignored there, and is then dropped in the data-valid phase to exercise idle and relock timing.

Reset pulses are sent one cycle shorter than the minimum and at the minimum. This pins down the qualification threshold. Bypass and the asynchronous power-up reset are each checked for their halt behaviour.

// File: rtl/xls_pkg.sv
package xls_pkg;

  typedef enum logic [2:0] {
    PH_HALT   = 3'd0,
    PH_BIAS   = 3'd1,
    PH_PLL    = 3'd2,
    PH_RXLK   = 3'd3,
    PH_SETTLE = 3'd4,
    PH_RUN    = 3'd5,
    PH_IDLE   = 3'd6,
    PH_RELOCK = 3'd7
  } phase_e;

  // Schedule boundaries in microseconds from time zero
  localparam int unsigned US_BIAS    = 32;
  localparam int unsigned US_PLL     = 262;
  localparam int unsigned US_RXLK    = 326;
  localparam int unsigned US_VALID   = 358;
  localparam int unsigned US_RELOCK  = 2;
  localparam int unsigned US_RST_MIN = 1;

  function automatic int unsigned us_to_cyc(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction

  function automatic int unsigned ctr_bits(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  // Phases whose length is set by the timer
  function automatic logic is_timed(input phase_e p);
    return (p == PH_BIAS) || (p == PH_PLL) || (p == PH_RXLK) ||
           (p == PH_SETTLE) || (p == PH_RELOCK);
  endfunction

endpackage

// File: rtl/xls_por_sync.sv
module xls_por_sync (
  input  logic clk,
  input  logic arst,
  output logic rst_o
);
  logic [1:0] q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) q <= 2'b11;
    else      q <= {q[0], 1'b0};
  end

  assign rst_o = q[1];
endmodule

// File: rtl/xls_sync.sv
module xls_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/xls_pulse_qual.sv
module xls_pulse_qual import xls_pkg::*; #(
  parameter int unsigned MIN_CYC = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic qual
);
  localparam int unsigned CW  = ctr_bits(MIN_CYC);
  localparam logic [CW-1:0] LIM = CW'(MIN_CYC - 1);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)              run_len <= '0;
    else if (!lvl)        run_len <= '0;
    else if (run_len != LIM) run_len <= run_len + 1'b1;
  end

  assign qual = lvl && (run_len == LIM);
endmodule

// File: rtl/xls_refresh_div.sv
module xls_refresh_div import xls_pkg::*; #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned DW = ctr_bits(DIV);
  localparam logic [DW-1:0] TOP = DW'(DIV - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == TOP);
endmodule

// File: rtl/xls_phase_ctl.sv
module xls_phase_ctl import xls_pkg::*; #(
  parameter int unsigned REF_MHZ = 125
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   halt,
  input  logic   track,
  output phase_e phase,
  output logic   bound_hit
);
  localparam int unsigned C_BIAS   = us_to_cyc(REF_MHZ, US_BIAS);
  localparam int unsigned C_PLL    = us_to_cyc(REF_MHZ, US_PLL);
  localparam int unsigned C_RXLK   = us_to_cyc(REF_MHZ, US_RXLK);
  localparam int unsigned C_VALID  = us_to_cyc(REF_MHZ, US_VALID);
  localparam int unsigned C_RELOCK = us_to_cyc(REF_MHZ, US_RELOCK);
  localparam int unsigned TW       = ctr_bits(C_VALID);

  // Last timer value of each timed phase; the timer runs from time zero
  function automatic logic [TW-1:0] phase_limit(input phase_e p);
    case (p)
      PH_BIAS:   return TW'(C_BIAS - 1);
      PH_PLL:    return TW'(C_PLL - 1);
      PH_RXLK:   return TW'(C_RXLK - 1);
      PH_SETTLE: return TW'(C_VALID - 1);
      PH_RELOCK: return TW'(C_RELOCK - 1);
      default:   return '1;
    endcase
  endfunction

  logic [TW-1:0] t;
  phase_e        nxt;
  logic          clr;

  assign bound_hit = is_timed(phase) && (t == phase_limit(phase));

  always_comb begin
    nxt = phase;
    clr = 1'b0;
    if (halt) begin
      nxt = PH_HALT;
      clr = 1'b1;
    end else begin
      case (phase)
        PH_HALT:   begin nxt = PH_BIAS; clr = 1'b1; end
        PH_BIAS:   if (bound_hit) nxt = PH_PLL;
        PH_PLL:    if (bound_hit) nxt = PH_RXLK;
        PH_RXLK:   if (bound_hit) nxt = PH_SETTLE;
        PH_SETTLE: if (bound_hit) nxt = PH_RUN;
        PH_RUN:    if (!track)    nxt = PH_IDLE;
        PH_IDLE:   if (track) begin nxt = PH_RELOCK; clr = 1'b1; end
        PH_RELOCK: begin
          if (!track)         nxt = PH_IDLE;
          else if (bound_hit) nxt = PH_RUN;
        end
        default:   nxt = PH_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase <= PH_HALT;
      t     <= '0;
    end else begin
      phase <= nxt;
      if (clr)                  t <= '0;
      else if (is_timed(phase)) t <= t + 1'b1;
    end
  end
endmodule

// File: rtl/xcvr_lock_seq.sv
module xcvr_lock_seq import xls_pkg::*; #(
  parameter int unsigned REF_MHZ     = 125,
  parameter int unsigned REFRESH_DIV = 16
) (
  input  logic       clk_ref,
  input  logic       pwr_up_rst,
  input  logic       rst_req,
  input  logic       pll_bypass,
  input  logic       sleep_req,
  input  logic       ref_track_en,
  input  logic       comma_req,
  output logic       pll_min_hold,
  output logic       rx_lock_start,
  output logic       data_valid,
  output logic       comma_det_en,
  output logic       ser_force,
  output logic       rx_word_hold,
  output logic       phase_sel_rst,
  output logic       dpll_filt_rst,
  output logic       pll_pwr_dn,
  output logic       refresh_en,
  output logic [2:0] phase_code
);
  localparam int unsigned RST_CYC = us_to_cyc(REF_MHZ, US_RST_MIN);
  localparam int unsigned NSYNC   = 5;
  localparam int unsigned I_RST   = 0;
  localparam int unsigned I_BYP   = 1;
  localparam int unsigned I_SLP   = 2;
  localparam int unsigned I_TRK   = 3;
  localparam int unsigned I_CMA   = 4;

  logic             rst_i;
  logic [NSYNC-1:0] raw_in, syn;
  logic             rst_s, byp_s, sleep_s, track_s, comma_s;
  logic             rst_qual, halt_req, bound_hit, refresh_tick;
  phase_e           phase;

  xls_por_sync u_por (.clk(clk_ref), .arst(pwr_up_rst), .rst_o(rst_i));

  assign raw_in[I_RST] = rst_req;
  assign raw_in[I_BYP] = pll_bypass;
  assign raw_in[I_SLP] = sleep_req;
  assign raw_in[I_TRK] = ref_track_en;
  assign raw_in[I_CMA] = comma_req;

  xls_sync #(.W(NSYNC)) u_sync (.clk(clk_ref), .rst(rst_i), .d(raw_in), .q(syn));

  assign rst_s   = syn[I_RST];
  assign byp_s   = syn[I_BYP];
  assign sleep_s = syn[I_SLP];
  assign track_s = syn[I_TRK];
  assign comma_s = syn[I_CMA];

  xls_pulse_qual #(.MIN_CYC(RST_CYC)) u_rstq (
    .clk(clk_ref), .rst(rst_i), .lvl(rst_s), .qual(rst_qual)
  );

  assign halt_req = rst_qual || byp_s || sleep_s;

  xls_phase_ctl #(.REF_MHZ(REF_MHZ)) u_ctl (
    .clk(clk_ref), .rst(rst_i), .halt(halt_req), .track(track_s),
    .phase(phase), .bound_hit(bound_hit)
  );

  xls_refresh_div #(.DIV(REFRESH_DIV)) u_div (
    .clk(clk_ref), .rst(rst_i), .en(sleep_s), .tick(refresh_tick)
  );

  assign phase_code    = phase;
  assign pll_min_hold  = (phase == PH_BIAS) || rst_qual;
  assign rx_lock_start = (phase >= PH_PLL);
  assign data_valid    = (phase == PH_RUN);
  assign comma_det_en  = data_valid && comma_s;
  assign ser_force     = rst_qual;
  assign rx_word_hold  = rst_qual;
  assign phase_sel_rst = rst_qual;
  assign dpll_filt_rst = rst_qual;
  assign pll_pwr_dn    = sleep_s;
  assign refresh_en    = refresh_tick;
endmodule

// File: rtl/xls_chk.sv
module xls_chk #(
  parameter int unsigned REF_MHZ     = 125,
  parameter int unsigned REFRESH_DIV = 16
) (
  input logic       clk,
  input logic       arst,
  input logic       rst_i,
  input logic       rst_s,
  input logic       byp_s,
  input logic [2:0] phase_code,
  input logic       data_valid,
  input logic       comma_det_en,
  input logic       ser_force,
  input logic       pll_pwr_dn,
  input logic       refresh_en
);
  localparam int unsigned C_BIAS   = REF_MHZ * 32;
  localparam int unsigned C_RELOCK = REF_MHZ * 2;
  localparam int unsigned RST_CYC  = REF_MHZ;

  int unsigned bias_cnt, relock_cnt, rs_cnt;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      bias_cnt   <= 0;
      relock_cnt <= 0;
      rs_cnt     <= 0;
    end else begin
      bias_cnt   <= (phase_code == 3'd1) ? bias_cnt + 1 : 0;
      relock_cnt <= (phase_code == 3'd7) ? relock_cnt + 1 : 0;
      rs_cnt     <= rst_s ? rs_cnt + 1 : 0;
    end
  end

  p_start_from_halt_r1: assert property (@(posedge clk) disable iff (arst || rst_i)
    (phase_code == 3'd1 && $past(phase_code) != 3'd1) |-> $past(phase_code) == 3'd0);

  p_bias_len_r2: assert property (@(posedge clk) disable iff (arst || rst_i)
    (phase_code == 3'd2 && $past(phase_code) == 3'd1) |-> bias_cnt == C_BIAS);

  p_phase_order_r3: assert property (@(posedge clk) disable iff (arst || rst_i)
    (phase_code != $past(phase_code) && phase_code >= 3'd2 && phase_code <= 3'd4)
      |-> phase_code == $past(phase_code) + 3'd1);

  p_valid_entry_r4: assert property (@(posedge clk) disable iff (arst || rst_i)
    $rose(data_valid) |-> ($past(phase_code) == 3'd4 || $past(phase_code) == 3'd7));

  p_comma_gated_r5: assert property (@(posedge clk) disable iff (arst || rst_i)
    comma_det_en |-> data_valid);

  p_relock_len_r6: assert property (@(posedge clk) disable iff (arst || rst_i)
    (phase_code == 3'd5 && $past(phase_code) == 3'd7) |-> relock_cnt == C_RELOCK);

  p_rst_qual_r8: assert property (@(posedge clk) disable iff (arst || rst_i)
    $rose(ser_force) |-> (rst_s && rs_cnt == RST_CYC - 1));

  p_rst_halts_r9: assert property (@(posedge clk) disable iff (arst || rst_i)
    ser_force |=> phase_code == 3'd0);

  p_sleep_halt_r10: assert property (@(posedge clk) disable iff (arst || rst_i)
    pll_pwr_dn |=> phase_code == 3'd0);

  p_refresh_sleep_r10: assert property (@(posedge clk) disable iff (arst || rst_i)
    refresh_en |-> pll_pwr_dn);

  p_bypass_halt_r11: assert property (@(posedge clk) disable iff (arst || rst_i)
    byp_s |=> phase_code == 3'd0);

  p_por_halt_r12: assert property (@(posedge clk)
    arst |-> (phase_code == 3'd0 && !data_valid));
endmodule

bind xcvr_lock_seq xls_chk #(.REF_MHZ(REF_MHZ), .REFRESH_DIV(REFRESH_DIV)) u_chk (
  .clk(clk_ref), .arst(pwr_up_rst), .rst_i(rst_i), .rst_s(rst_s), .byp_s(byp_s),
  .phase_code(phase_code), .data_valid(data_valid), .comma_det_en(comma_det_en),
  .ser_force(ser_force), .pll_pwr_dn(pll_pwr_dn), .refresh_en(refresh_en)
);

// File: tb/sim_xcvr_lock_seq.sv
module sim_xcvr_lock_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ   = 2;
  localparam int DIV   = 4;
  localparam int C32   = 32 * MHZ;
  localparam int C262  = 262 * MHZ;
  localparam int C326  = 326 * MHZ;
  localparam int C358  = 358 * MHZ;
  localparam int C2    = 2 * MHZ;
  localparam int NTICK = 5;

  logic clk = 1'b0;
  logic por, rst, byp, slp, track, comma;
  logic pll_min_hold, rx_lock_start, data_valid, comma_det_en, ser_force;
  logic rx_word_hold, phase_sel_rst, dpll_filt_rst, pll_pwr_dn, refresh_en;
  logic [2:0] phase_code;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xcvr_lock_seq #(.REF_MHZ(MHZ), .REFRESH_DIV(DIV)) u0 (
    .clk_ref(clk), .pwr_up_rst(por), .rst_req(rst), .pll_bypass(byp),
    .sleep_req(slp), .ref_track_en(track), .comma_req(comma),
    .pll_min_hold(pll_min_hold), .rx_lock_start(rx_lock_start),
    .data_valid(data_valid), .comma_det_en(comma_det_en), .ser_force(ser_force),
    .rx_word_hold(rx_word_hold), .phase_sel_rst(phase_sel_rst),
    .dpll_filt_rst(dpll_filt_rst), .pll_pwr_dn(pll_pwr_dn),
    .refresh_en(refresh_en), .phase_code(phase_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_code(input int e);
    if (e < C32)  return 1;
    if (e < C262) return 2;
    if (e < C326) return 3;
    if (e < C358) return 4;
    return 5;
  endfunction

  // Called at the first phase-1 sample; walks past the data-valid boundary
  task automatic walk(input int comma_on, input int raise_at);
    for (int e = 0; e <= C358 + 3; e++) begin
      if (raise_at >= 0 && e == raise_at - 1)
        chk("R7 track ignored", int'(phase_code), exp_code(e));
      if (e == raise_at) track = 1'b1;
      chk("R3 phase", int'(phase_code), exp_code(e));
      chk("R2 min hold", int'(pll_min_hold), int'(e < C32));
      chk("R3 lock start", int'(rx_lock_start), int'(e >= C32));
      chk("R4 valid", int'(data_valid), int'(e >= C358));
      chk("R5 comma", int'(comma_det_en), int'(e >= C358 && comma_on != 0));
      chk("R10 no refresh", int'(refresh_en), 0);
      step(1);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int ticks;
    por = 1'b1; rst = 1'b0; byp = 1'b0; slp = 1'b0; track = 1'b1; comma = 1'b1;
    step(3);
    // R12 reset state
    chk("R12 reset phase", int'(phase_code), 0);
    chk("R12 reset valid", int'(data_valid), 0);
    chk("R9 reset force", int'(ser_force), 0);
    chk("R10 reset pwr dn", int'(pll_pwr_dn), 0);

    // R1 power-up release
    por = 1'b0;
    step(2);
    chk("R1 still halted", int'(phase_code), 0);
    step(1);
    chk("R1 start", int'(phase_code), 1);
    walk(1, -1);

    // R6 idle and relock
    track = 1'b0;
    step(2);
    chk("R6 before idle", int'(phase_code), 5);
    step(1);
    chk("R6 idle", int'(phase_code), 6);
    chk("R6 idle valid", int'(data_valid), 0);
    chk("R5 idle comma", int'(comma_det_en), 0);
    step(5);
    chk("R6 idle stays", int'(phase_code), 6);
    track = 1'b1;
    step(2);
    chk("R6 before relock", int'(phase_code), 6);
    step(1);
    chk("R6 relock", int'(phase_code), 7);
    step(C2 - 1);
    chk("R6 relock end", int'(phase_code), 7);
    chk("R6 relock invalid", int'(data_valid), 0);
    step(1);
    chk("R6 back to run", int'(phase_code), 5);
    chk("R6 valid again", int'(data_valid), 1);

    // R8 short reset pulse ignored
    rst = 1'b1;
    step(MHZ - 1);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R8 short force", int'(ser_force), 0);
      chk("R8 short hold", int'(rx_word_hold), 0);
      chk("R8 short phase", int'(phase_code), 5);
    end

    // R9 qualified reset, then restart with tracking low (R7) and comma off
    comma = 1'b0;
    rst = 1'b1;
    step(2);
    chk("R8 not yet", int'(ser_force), 0);
    step(1);
    chk("R9 force", int'(ser_force), 1);
    chk("R9 min hold", int'(pll_min_hold), 1);
    chk("R9 word hold", int'(rx_word_hold), 1);
    chk("R9 phase sel", int'(phase_sel_rst), 1);
    chk("R9 dpll", int'(dpll_filt_rst), 1);
    step(1);
    chk("R9 halted", int'(phase_code), 0);
    rst = 1'b0;
    track = 1'b0;
    step(1);
    chk("R9 force held", int'(ser_force), 1);
    step(1);
    chk("R9 force off", int'(ser_force), 0);
    chk("R9 still halted", int'(phase_code), 0);
    step(1);
    chk("R9 restart", int'(phase_code), 1);
    walk(0, C262);

    // R10 low power
    comma = 1'b1;
    slp = 1'b1;
    step(2);
    chk("R10 pwr dn", int'(pll_pwr_dn), 1);
    ticks = 0;
    for (int k = 0; k < NTICK * DIV; k++) begin
      if (refresh_en) ticks++;
      if (k == 1) chk("R10 halted", int'(phase_code), 0);
      step(1);
    end
    chk("R10 refresh count", ticks, NTICK);
    slp = 1'b0;
    step(2);
    chk("R10 pwr up", int'(pll_pwr_dn), 0);
    chk("R10 still halted", int'(phase_code), 0);
    step(1);
    chk("R10 restart", int'(phase_code), 1);
    walk(1, -1);

    // R11 bypass
    byp = 1'b1;
    step(2);
    chk("R11 before halt", int'(phase_code), 5);
    step(1);
    chk("R11 halt", int'(phase_code), 0);
    chk("R11 invalid", int'(data_valid), 0);
    byp = 1'b0;
    step(2);
    chk("R11 still halted", int'(phase_code), 0);
    step(1);
    chk("R11 restart", int'(phase_code), 1);
    step(4);

    // R12 asynchronous power-up reset
    por = 1'b1;
    #1;
    chk("R12 async phase", int'(phase_code), 0);
    chk("R12 async valid", int'(data_valid), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule